// File: doc/BRIEF.md
# Striped Block Request Splitter

This block turns one byte-addressed transfer request into a sequence of per-block commands for a storage array that interleaves its address space across several target channels. A request carries a start address, a byte length and a kind (read, write or discard). The block walks the request one 4096-byte block at a time and emits one command per step. Each command carries the target channel, the logical block address inside that target, and the part of the block that is touched, given as a 512-byte sector offset and sector count.

The array is striped at a power-of-two granularity across a power-of-two number of targets. Both values come in on configuration inputs and are expected to be held steady. If either value is not a power of two, the block reports a configuration error and refuses all requests. Requests and commands each use a valid/ready handshake. The block works on one request at a time and accepts the next one only after the last command of the current one has been taken.

Top module: `blk_stripe_splitter`

## Requirements
- R1: After reset, with a legal configuration, `cmdValid` is 0 and `reqReady` is 1.
- R2: `cmdTarget` equals floor(A / S) mod T, where A is the command's byte address, S is `stripeBytes` and T is `tgtCount`.
- R3: `cmdLaddr` equals (floor(floor(A / T) / S) * S + (A mod S)) / 4096.
- R4: For kinds other than discard (`reqKind` 0 = read, 1 = write, 3 = handled like a read), each command covers min(remaining length, 4096 - (A mod 4096)) bytes. The address then moves forward by that amount. The request yields exactly as many commands as this walk needs, in ascending address order.
- R5: For these kinds, `cmdSubOff` is (A mod 4096) / 512. `cmdSubCnt` is the covered length / 512 taken modulo 8, so 0 stands for a whole block.
- R6: `cmdSub` packs the sector count in bits [6:4] and the sector offset in bits [2:0]. Bits 7 and 3 are 0.
- R7: A discard (`reqKind` = 2) is cut into whole blocks. Each command has sector offset 0 and sector count 0, and the address moves by 4096 per command.
- R8: While `cmdValid` is 1 and `cmdReady` is 0, the command and all its fields stay unchanged on the next cycle.
- R9: A request is taken only while `reqReady` is 1. `reqReady` is 0 while commands are being issued. A request of length 0 produces no command.
- R10: `cfgErr` is 1 when `stripeBytes` or `tgtCount` is zero or not a power of two. In that state `reqReady` is 0 and no command is issued.
- R11: `cmdKind` repeats the request kind, and `cmdLast` is 1 exactly on the final command of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stripeBytes | input | ADDR_W | Stripe granularity in bytes (power of two) |
| tgtCount | input | MAX_TGT_LOG2+1 | Number of targets (power of two) |
| cfgErr | output | 1 | Configuration is illegal |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqAddr | input | ADDR_W | Request start byte address (multiple of 512) |
| reqLen | input | LEN_W | Request length in bytes (multiple of 512) |
| reqKind | input | 2 | 0 read, 1 write, 2 discard, 3 read-style |
| cmdValid | output | 1 | Command present |
| cmdReady | input | 1 | Command taken |
| cmdTarget | output | MAX_TGT_LOG2 | Target channel index |
| cmdLaddr | output | ADDR_W-12 | Logical block address in the target |
| cmdKind | output | 2 | Kind of the owning request |
| cmdSubOff | output | 3 | Sector offset inside the block |
| cmdSubCnt | output | 3 | Sector count, 0 means whole block |
| cmdSub | output | 8 | Packed count/offset byte |
| cmdLast | output | 1 | Final command of the request |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 20-bit length and up to 8 targets. These reach the top bits of the striping shifts and the full width of the target index. The bench changes the configuration inputs between scenarios to cover stripes of 4096, 8192 and 16384 bytes across 2, 4 and 8 targets. That shows the target index and the logical address reacting to both shift amounts. Requests start mid-block, end mid-block and fit inside one block. The command side is throttled throughout, so every command is also seen while it is being held.

// File: rtl/stripe_split_pkg.sv
package stripe_split_pkg;
  typedef enum logic [1:0] {
    KIND_READ    = 2'b00,
    KIND_WRITE   = 2'b01,
    KIND_DISCARD = 2'b10,
    KIND_RSVD    = 2'b11
  } reqKind_e;

  typedef struct packed {
    logic load;
    logic advance;
  } splitStrobe_t;

  localparam int unsigned BLK_LOG2  = 12;
  localparam int unsigned SECT_LOG2 = 9;
endpackage

// File: rtl/stripe_split_dp.sv
module stripe_split_dp
  import stripe_split_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned LEN_W        = 20,
  parameter int unsigned MAX_TGT_LOG2 = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  splitStrobe_t              strobe,
  input  logic [ADDR_W-1:0]         stripeBytes,
  input  logic [MAX_TGT_LOG2:0]     tgtCount,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic [1:0]                reqKind,
  output logic                      zeroLen,
  output logic                      lastChunk,
  output logic [MAX_TGT_LOG2-1:0]   cmdTarget,
  output logic [ADDR_W-BLK_LOG2-1:0] cmdLaddr,
  output logic [1:0]                cmdKind,
  output logic [2:0]                cmdSubOff,
  output logic [2:0]                cmdSubCnt
);
  localparam int unsigned SH_W    = $clog2(ADDR_W);
  localparam int unsigned TCNT_W  = MAX_TGT_LOG2 + 1;
  localparam int unsigned LADDR_W = ADDR_W - BLK_LOG2;
  localparam logic [LEN_W-1:0] BLK_BYTES = LEN_W'(1) << BLK_LOG2;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [1:0]        curKind;
  logic [SH_W-1:0]   stripeSh;
  logic [SH_W-1:0]   tgtSh;
  logic [LEN_W-1:0]  room;
  logic [LEN_W-1:0]  chunk;
  logic [ADDR_W-1:0] stripeMask;
  logic [ADDR_W-1:0] joined;
  logic              isDisc;

  // shift amounts from the single set bit of each power-of-two setting
  always_comb begin
    stripeSh = '0;
    for (int i = 0; i < ADDR_W; i++)
      if (stripeBytes[i]) stripeSh = SH_W'(i);
  end

  always_comb begin
    tgtSh = '0;
    for (int i = 0; i < TCNT_W; i++)
      if (tgtCount[i]) tgtSh = SH_W'(i);
  end

  assign isDisc     = (curKind == KIND_DISCARD);
  assign room       = BLK_BYTES - LEN_W'(curAddr[BLK_LOG2-1:0]);
  assign chunk      = isDisc ? BLK_BYTES : ((remLen < room) ? remLen : room);
  assign lastChunk  = (remLen <= chunk);
  assign zeroLen    = (reqLen == '0);

  assign stripeMask = stripeBytes - ADDR_W'(1);
  assign joined     = ((curAddr >> tgtSh) & ~stripeMask) | (curAddr & stripeMask);
  assign cmdLaddr   = LADDR_W'(joined >> BLK_LOG2);
  assign cmdTarget  = MAX_TGT_LOG2'((curAddr >> stripeSh) & (ADDR_W'(tgtCount) - ADDR_W'(1)));
  assign cmdKind    = curKind;
  assign cmdSubOff  = isDisc ? 3'd0 : curAddr[BLK_LOG2-1:SECT_LOG2];
  assign cmdSubCnt  = isDisc ? 3'd0 : chunk[BLK_LOG2-1:SECT_LOG2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      curKind <= KIND_READ;
    end else if (strobe.load) begin
      curAddr <= reqAddr;
      remLen  <= reqLen;
      curKind <= reqKind;
    end else if (strobe.advance) begin
      curAddr <= curAddr + ADDR_W'(chunk);
      remLen  <= lastChunk ? '0 : (remLen - chunk);
    end
  end
endmodule

// File: rtl/stripe_split_ctrl.sv
module stripe_split_ctrl
  import stripe_split_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned MAX_TGT_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     stripeBytes,
  input  logic [MAX_TGT_LOG2:0] tgtCount,
  input  logic                  reqValid,
  input  logic                  cmdReady,
  input  logic                  zeroLen,
  input  logic                  lastChunk,
  output logic                  reqReady,
  output logic                  cmdValid,
  output logic                  cfgErr,
  output splitStrobe_t          strobe
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state;
  logic   stripeOk;
  logic   tgtOk;
  logic   accept;

  assign stripeOk = (stripeBytes != '0) && ((stripeBytes & (stripeBytes - 1'b1)) == '0);
  assign tgtOk    = (tgtCount != '0) && ((tgtCount & (tgtCount - 1'b1)) == '0);
  assign cfgErr   = !(stripeOk && tgtOk);

  assign reqReady = (state == ST_IDLE) && !cfgErr;
  assign cmdValid = (state == ST_RUN);
  assign accept   = reqValid && reqReady;

  assign strobe.load    = accept;
  assign strobe.advance = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept && !zeroLen) state <= ST_RUN;
        ST_RUN:  if (cmdReady && lastChunk) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_stripe_splitter.sv
module blk_stripe_splitter
  import stripe_split_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned LEN_W        = 20,
  parameter int unsigned MAX_TGT_LOG2 = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             stripeBytes,
  input  logic [MAX_TGT_LOG2:0]         tgtCount,
  output logic                          cfgErr,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [LEN_W-1:0]              reqLen,
  input  logic [1:0]                    reqKind,
  output logic                          cmdValid,
  input  logic                          cmdReady,
  output logic [MAX_TGT_LOG2-1:0]       cmdTarget,
  output logic [ADDR_W-BLK_LOG2-1:0]    cmdLaddr,
  output logic [1:0]                    cmdKind,
  output logic [2:0]                    cmdSubOff,
  output logic [2:0]                    cmdSubCnt,
  output logic [7:0]                    cmdSub,
  output logic                          cmdLast
);
  localparam int unsigned LADDR_W = ADDR_W - BLK_LOG2;

  splitStrobe_t strobe;
  logic         zeroLen;
  logic         lastChunk;

  stripe_split_ctrl #(.ADDR_W(ADDR_W), .MAX_TGT_LOG2(MAX_TGT_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .stripeBytes(stripeBytes), .tgtCount(tgtCount),
    .reqValid(reqValid), .cmdReady(cmdReady), .zeroLen(zeroLen),
    .lastChunk(lastChunk), .reqReady(reqReady), .cmdValid(cmdValid),
    .cfgErr(cfgErr), .strobe(strobe)
  );

  stripe_split_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_TGT_LOG2(MAX_TGT_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stripeBytes(stripeBytes),
    .tgtCount(tgtCount), .reqAddr(reqAddr), .reqLen(reqLen), .reqKind(reqKind),
    .zeroLen(zeroLen), .lastChunk(lastChunk), .cmdTarget(cmdTarget),
    .cmdLaddr(cmdLaddr), .cmdKind(cmdKind), .cmdSubOff(cmdSubOff),
    .cmdSubCnt(cmdSubCnt)
  );

  assign cmdSub  = {1'b0, cmdSubCnt, 1'b0, cmdSubOff};
  assign cmdLast = cmdValid && lastChunk;
endmodule

// File: rtl/stripe_split_chk.sv
module stripe_split_chk #(
  parameter int unsigned TGT_IDX_W = 3,
  parameter int unsigned LADDR_W   = 20
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgErr,
  input logic                 reqReady,
  input logic                 cmdValid,
  input logic                 cmdReady,
  input logic [TGT_IDX_W-1:0] cmdTarget,
  input logic [LADDR_W-1:0]   cmdLaddr,
  input logic [1:0]           cmdKind,
  input logic [2:0]           cmdSubOff,
  input logic [2:0]           cmdSubCnt,
  input logic [7:0]           cmdSub,
  input logic                 cmdLast
);
  logic [3:0] spanSect;
  assign spanSect = {1'b0, cmdSubOff} + ((cmdSubCnt == 3'd0) ? 4'd8 : {1'b0, cmdSubCnt});

  a_r8_hold_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdTarget) && $stable(cmdLaddr)
      && $stable(cmdKind) && $stable(cmdSub) && $stable(cmdLast));

  a_r10_cfg_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !reqReady);

  a_r9_one_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  a_r6_packed_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdSub[7] == 1'b0) && (cmdSub[3] == 1'b0));

  a_r7_discard_whole: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdKind == 2'b10) |-> (cmdSubOff == 3'd0) && (cmdSubCnt == 3'd0));

  a_r5_inside_block: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdKind != 2'b10) |-> spanSect <= 4'd8);
endmodule

bind blk_stripe_splitter stripe_split_chk #(.TGT_IDX_W(MAX_TGT_LOG2), .LADDR_W(LADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgErr(cfgErr), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdTarget(cmdTarget), .cmdLaddr(cmdLaddr), .cmdKind(cmdKind),
  .cmdSubOff(cmdSubOff), .cmdSubCnt(cmdSubCnt), .cmdSub(cmdSub), .cmdLast(cmdLast)
);

// File: tb/blk_stripe_splitter_bench.sv
module blk_stripe_splitter_bench;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 20;
  localparam int unsigned MTL    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] stripeBytes = 32'h1000;
  logic [MTL:0]      tgtCount = 4'd4;
  logic              cfgErr;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic [1:0]        reqKind = '0;
  logic              cmdValid;
  logic              cmdReady = 1'b0;
  logic [MTL-1:0]    cmdTarget;
  logic [ADDR_W-13:0] cmdLaddr;
  logic [1:0]        cmdKind;
  logic [2:0]        cmdSubOff;
  logic [2:0]        cmdSubCnt;
  logic [7:0]        cmdSub;
  logic              cmdLast;

  int nChk = 0;
  int nErr = 0;
  int throttle = 0;

  always #5 clk = ~clk;

  blk_stripe_splitter u_blk_stripe_splitter (
    .clk(clk), .rstN(rstN), .stripeBytes(stripeBytes), .tgtCount(tgtCount),
    .cfgErr(cfgErr), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqKind(reqKind), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdTarget(cmdTarget), .cmdLaddr(cmdLaddr), .cmdKind(cmdKind),
    .cmdSubOff(cmdSubOff), .cmdSubCnt(cmdSubCnt), .cmdSub(cmdSub), .cmdLast(cmdLast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendReq(input longint addr, input longint len, input logic [1:0] kind);
    @(negedge clk);
    reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len); reqKind = kind; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // walks the expected command list and compares every presented command
  task automatic expectSeq(input longint addr, input longint len, input logic [1:0] kind);
    longint a = addr;
    longint rem = len;
    longint s = longint'(stripeBytes);
    longint t = longint'(tgtCount);
    int guard = 0;
    bit first = 1;
    while (rem > 0 && guard < 2000) begin
      guard++;
      if (first) begin
        chk(cmdValid == 1'b1, "R9 command follows accept", cmdValid, 1);
        chk(reqReady == 1'b0, "R9 busy blocks requests", reqReady, 0);
        first = 0;
      end
      if (cmdValid) begin
        longint off = a % 4096;
        longint ch = (kind == 2'b10) ? 4096 : ((rem < 4096 - off) ? rem : 4096 - off);
        longint eTgt = (a / s) % t;
        longint eLad = (((a / t) / s) * s + (a % s)) / 4096;
        longint eOff = (kind == 2'b10) ? 0 : off / 512;
        longint eCnt = (kind == 2'b10) ? 0 : (ch / 512) % 8;
        chk(longint'(cmdTarget) == eTgt, "R2 target", cmdTarget, eTgt);
        chk(longint'(cmdLaddr) == eLad, "R3 logical block", cmdLaddr, eLad);
        if (kind == 2'b10) begin
          chk(cmdSubOff == 0 && cmdSubCnt == 0, "R7 discard whole block", {cmdSubCnt, cmdSubOff}, 0);
        end else begin
          chk(longint'(cmdSubOff) == eOff, "R5 sector offset", cmdSubOff, eOff);
          chk(longint'(cmdSubCnt) == eCnt, "R4/R5 sector count", cmdSubCnt, eCnt);
        end
        chk(longint'(cmdSub) == eCnt * 16 + eOff, "R6 packed byte", cmdSub, eCnt * 16 + eOff);
        chk(cmdKind == kind, "R11 kind", cmdKind, kind);
        chk(cmdLast == (rem <= ch), "R11 last flag", cmdLast, (rem <= ch));
      end
      cmdReady = ((throttle % 3) != 2);
      throttle++;
      if (cmdValid && cmdReady) begin
        longint off2 = a % 4096;
        longint ch2 = (kind == 2'b10) ? 4096 : ((rem < 4096 - off2) ? rem : 4096 - off2);
        a = a + ch2;
        rem = (rem <= ch2) ? 0 : rem - ch2;
      end
      @(negedge clk);
    end
    cmdReady = 1'b0;
    chk(cmdValid == 1'b0, "R4 no extra command", cmdValid, 0);
    chk(reqReady == 1'b1, "R9 ready after request", reqReady, 1);
  endtask

  task automatic runReq(input longint addr, input longint len, input logic [1:0] kind);
    sendReq(addr, len, kind);
    expectSeq(addr, len, kind);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(cmdValid == 1'b0, "R1 cmdValid after reset", cmdValid, 0);
    chk(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    chk(cfgErr == 1'b0, "R10 legal config", cfgErr, 0);
  endtask

  task automatic testAlignedWrite();
    stripeBytes = 32'h1000; tgtCount = 4'd4;
    runReq(64'h3000, 64'h3000, 2'b01);
  endtask

  task automatic testUnalignedRead();
    stripeBytes = 32'h2000; tgtCount = 4'd2;
    runReq(64'h0001_1A00, 64'h2C00, 2'b00);
    runReq(64'h0004_5200, 64'h400, 2'b00);
    runReq(64'h0000_7E00, 64'h200, 2'b11);
  endtask

  task automatic testDiscard();
    stripeBytes = 32'h4000; tgtCount = 4'd8;
    runReq(64'h0012_8000, 64'h5000, 2'b10);
  endtask

  task automatic testZeroLen();
    sendReq(64'h1000, 0, 2'b01);
    chk(cmdValid == 1'b0, "R9 zero length gives no command", cmdValid, 0);
    @(negedge clk);
    chk(cmdValid == 1'b0, "R9 zero length still idle", cmdValid, 0);
    chk(reqReady == 1'b1, "R9 ready after zero length", reqReady, 1);
  endtask

  task automatic testBadConfig();
    @(negedge clk);
    stripeBytes = 32'h3000; tgtCount = 4'd4;
    @(negedge clk);
    chk(cfgErr == 1'b1, "R10 stripe not power of two", cfgErr, 1);
    chk(reqReady == 1'b0, "R10 requests refused", reqReady, 0);
    reqAddr = 32'h2000; reqLen = 20'h1000; reqKind = 2'b01; reqValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmdValid == 1'b0, "R10 no command under bad config", cmdValid, 0);
    end
    stripeBytes = 32'h1000; tgtCount = 4'd3;
    @(negedge clk);
    chk(cfgErr == 1'b1, "R10 target count not power of two", cfgErr, 1);
    chk(cmdValid == 1'b0, "R10 no command", cmdValid, 0);
    tgtCount = 4'd0;
    @(negedge clk);
    chk(cfgErr == 1'b1, "R10 target count zero", cfgErr, 1);
    reqValid = 1'b0;
    tgtCount = 4'd4;
    @(negedge clk);
    chk(cfgErr == 1'b0, "R10 legal again", cfgErr, 0);
    chk(cmdValid == 1'b0, "R10 held request not taken", cmdValid, 0);
    chk(reqReady == 1'b1, "R10 ready again", reqReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAlignedWrite();
    testUnalignedRead();
    testDiscard();
    testZeroLen();
    testBadConfig();
    stripeBytes = 32'h2000; tgtCount = 4'd4;
    runReq(64'h0003_0600, 64'h3400, 2'b01);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule